// File: doc/BRIEF.md
# Two-Wire Serial Byte-Memory Target

This block is a synthesizable target on a two-wire serial bus that behaves as a small byte-wide non-volatile memory of 128 or 256 locations. The bus clock and data lines arrive as plain inputs sampled by the system clock. The block pulls the data line low through an enable output, and the pad logic turns that enable into an open-drain driver. The block recognises bus start and stop conditions and answers only to the fixed 7-bit device identity 1010000. It then takes a one-byte location pointer, after which it either collects written bytes or returns stored bytes.

Written bytes gather in a 16-entry page buffer and are copied into the array only when the master closes the transfer with a stop condition. A write-protect input discards data while it is high. After each commit a busy window of a parameterised number of clock cycles follows. During that window the block refuses its own identity, so the master can poll for completion. Reads can start from a pointer the master has just set, or continue from the current one, and they stream bytes until the master declines one.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. Before the first start the block never pulls the data line low, even when full bytes are clocked past it.
- R2: After a start, the first byte is acknowledged (data pulled low during the ninth clock) only when its upper seven bits are 1010000. Any other identity, for example 1010001 or 1011000, is left unacknowledged.
- R3: The eighth bit of the identity byte selects the direction: 0 means the master writes a pointer and data, and 1 means the block returns data.
- R4: Incoming bits are taken on the clock's rising edge. The block changes its data-line drive only while the clock line is low, and it never pulls the line low during the eight data bits the master sends.
- R5: The first byte after a write identity sets the location pointer. A repeated start followed by a read identity then returns the byte at that location.
- R6: Data bytes go into the page buffer and reach the array only at a stop. A repeated start before the stop discards them, and no busy window follows.
- R7: During a write, the low four pointer bits advance and wrap inside the 16-byte page while the upper bits stay fixed. A write that starts at offset 0xE of a page and carries five bytes lands on offsets 0xE, 0xF, 0x0, 0x1 and 0x2 of the same page.
- R8: A read advances the pointer after every byte and wraps from the last location to location 0. The read ends when the master answers a byte with no-acknowledge and a stop, and the block then leaves the data line released.
- R9: While the write-protect input is high, the pointer and data bytes are still acknowledged but nothing is written and no busy window starts. Reads are unaffected.
- R10: A commit starts a busy window of WR_CYCLES clock cycles, during which the device identity is not acknowledged. After the window ends the identity is acknowledged again.
- R11: After reset the data-line drive is off and every array location reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (resolved wired-AND value) |
| wp_i | input | 1 | Write protect: high blocks every write |
| sda_oe | output | 1 | High pulls the bus data line low |

## Verification
The situation that is hardest to reach from the ports is a commit that must not happen: a page buffer holding bytes whose transfer is cut off by a repeated start, or bytes taken in while write protect is high. Nothing in the bus protocol reports either outcome. The bench therefore polls the identity straight after the stop, and an immediate acknowledge shows that no busy window started. It then reads the location back to confirm that it still holds its reset value. The busy window itself is reached by polling right after a real commit, with WR_CYCLES scaled down so that the first polls are refused and a later poll is acknowledged.

// File: rtl/eep_pkg.sv
// Shared definitions for the serial byte-memory target.
// Holds the protocol state encoding and the fixed device identity.
package eep_pkg;

    localparam int          BYTE_W = 8;
    localparam logic [6:0]  DEV_ID = 7'b1010000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } eep_state_t;

endpackage

// File: rtl/eep_bus_sync.sv
// Synchronises the bus clock and data lines into the system clock domain
// and derives clock edges plus start/stop conditions from them.
// Assumes the system clock is several times faster than the bus clock;
// both lines pass through the same number of stages, so they stay aligned.
module eep_bus_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int N = SYNC_STAGES;

    logic [N:0] scl_sh;
    logic [N:0] sda_sh;
    logic       scl_cur, scl_prev, sda_prev;

    // Shift both lines through the synchroniser; idle bus level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[N-1:0], scl_i};
            sda_sh <= {sda_sh[N-1:0], sda_i};
        end
    end

    // Current and previous synchronised samples, and the derived events.
    always_comb begin
        scl_cur   = scl_sh[N-1];
        scl_prev  = scl_sh[N];
        sda_q     = sda_sh[N-1];
        sda_prev  = sda_sh[N];
        scl_rise  = scl_cur & ~scl_prev;
        scl_fall  = ~scl_cur & scl_prev;
        start_det = scl_cur & scl_prev & sda_prev & ~sda_q;
        stop_det  = scl_cur & scl_prev & ~sda_prev & sda_q;
    end

endmodule

// File: rtl/eep_busy_timer.sv
// Counts out the internal write window after a commit.
// busy is high for exactly CYCLES clocks following the start pulse.
module eep_busy_timer #(
    parameter int CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= CW'(CYCLES);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/eep_page_buf.sv
// Page buffer: holds one page of pending write bytes and a mask of which
// offsets have been written since the last clear. Clear wins over write.
module eep_page_buf #(
    parameter int PAGE_BYTES = 16,
    localparam int PW = $clog2(PAGE_BYTES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          wr_en,
    input  logic [PW-1:0]                 wr_idx,
    input  logic [7:0]                    wr_data,
    output logic [PAGE_BYTES-1:0][7:0]    page_data,
    output logic [PAGE_BYTES-1:0]         page_mask
);

    // Capture a byte at its page offset and flag the offset as pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_data <= '0;
            page_mask <= '0;
        end else if (clr) begin
            page_mask <= '0;
        end else if (wr_en) begin
            page_data[wr_idx] <= wr_data;
            page_mask[wr_idx] <= 1'b1;
        end
    end

endmodule

// File: rtl/eep_array.sv
// Byte array with a masked whole-page commit port and a combinational read.
// Assumes DEPTH is a power of two and a multiple of PAGE_BYTES.
module eep_array #(
    parameter int DEPTH      = 256,
    parameter int PAGE_BYTES = 16,
    localparam int AW  = $clog2(DEPTH),
    localparam int PW  = $clog2(PAGE_BYTES),
    localparam int PSW = AW - PW
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        commit,
    input  logic [PSW-1:0]              page_sel,
    input  logic [PAGE_BYTES-1:0][7:0]  page_data,
    input  logic [PAGE_BYTES-1:0]       page_mask,
    input  logic [AW-1:0]               rd_addr,
    output logic [7:0]                  rd_data
);
    logic [7:0] mem [DEPTH];

    // Clear on reset; on commit copy every pending byte of the page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < DEPTH; j++)
                mem[j] <= '0;
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                if (page_mask[i])
                    mem[{page_sel, PW'(i)}] <= page_data[i];
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/i2c_eeprom_target.sv
// Two-wire bus target emulating a small byte memory.
// Protocol FSM: identity match, pointer load, page-buffered writes committed
// at stop, streaming reads, write protect and a busy window after commits.
// Assumes the bus is driven well below clk/8 so that the synchronised view
// settles within each bus clock phase; no clock stretching is performed.
module i2c_eeprom_target
    import eep_pkg::*;
#(
    parameter int MEM_DEPTH   = 256,
    parameter int PAGE_BYTES  = 16,
    parameter int WR_CYCLES   = 250000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_oe
);
    localparam int AW  = $clog2(MEM_DEPTH);
    localparam int PW  = $clog2(PAGE_BYTES);
    localparam int PSW = AW - PW;

    logic       sda_q, scl_rise, scl_fall, start_det, stop_det;
    logic       busy, commit, pb_clr, pb_wr;
    logic [1:0] wp_sh;
    logic       wp_q;

    eep_state_t  state;
    logic [3:0]  bitcnt;
    logic [7:0]  rx_sr;
    logic [7:0]  tx_sr;
    logic [AW-1:0] ptr;
    logic        rw;
    logic        mst_ack;
    logic        byte_done;
    logic        dev_hit;

    logic [PAGE_BYTES-1:0][7:0] pg_data;
    logic [PAGE_BYTES-1:0]      pg_mask;
    logic [7:0]                 rd_data;

    eep_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_q     (sda_q),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    eep_busy_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (commit),
        .busy  (busy)
    );

    eep_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_pbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (pb_clr),
        .wr_en     (pb_wr),
        .wr_idx    (ptr[PW-1:0]),
        .wr_data   (rx_sr),
        .page_data (pg_data),
        .page_mask (pg_mask)
    );

    eep_array #(.DEPTH(MEM_DEPTH), .PAGE_BYTES(PAGE_BYTES)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .page_sel  (ptr[AW-1:PW]),
        .page_data (pg_data),
        .page_mask (pg_mask),
        .rd_addr   (ptr),
        .rd_data   (rd_data)
    );

    // Write-protect level synchroniser.
    always_ff @(posedge clk) begin
        if (!rst_n) wp_sh <= '0;
        else        wp_sh <= {wp_sh[0], wp_i};
    end
    assign wp_q = wp_sh[1];

    // Byte boundary, identity match and buffer/commit controls.
    always_comb begin
        byte_done = scl_fall && (bitcnt == 4'd8);
        dev_hit   = (rx_sr[7:1] == DEV_ID) && !busy;
        pb_wr     = (state == ST_WDATA) && byte_done && !wp_q;
        commit    = stop_det && (|pg_mask);
        pb_clr    = start_det || stop_det;
    end

    // Protocol state machine: bit shifting, acknowledge and read drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
            ptr     <= '0;
            rw      <= 1'b0;
            mst_ack <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else if (start_det) begin
            state  <= ST_DEV;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_DEV: begin
                    if (scl_rise) begin
                        rx_sr  <= {rx_sr[6:0], sda_q};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_done) begin
                        bitcnt <= '0;
                        if (dev_hit) begin
                            sda_oe <= 1'b1;
                            rw     <= rx_sr[0];
                            state  <= ST_DEV_ACK;
                        end else begin
                            state  <= ST_IDLE;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (rw) begin
                            tx_sr  <= {rd_data[6:0], 1'b0};
                            sda_oe <= ~rd_data[7];
                            ptr    <= ptr + 1'b1;
                            state  <= ST_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_WADDR;
                        end
                    end
                end
                ST_WADDR: begin
                    if (scl_rise) begin
                        rx_sr  <= {rx_sr[6:0], sda_q};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_done) begin
                        bitcnt <= '0;
                        ptr    <= rx_sr[AW-1:0];
                        sda_oe <= 1'b1;
                        state  <= ST_WADDR_ACK;
                    end
                end
                ST_WADDR_ACK: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_WDATA;
                    end
                end
                ST_WDATA: begin
                    if (scl_rise) begin
                        rx_sr  <= {rx_sr[6:0], sda_q};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_done) begin
                        bitcnt <= '0;
                        ptr    <= {ptr[AW-1:PW], ptr[PW-1:0] + 1'b1};
                        sda_oe <= 1'b1;
                        state  <= ST_WDATA_ACK;
                    end
                end
                ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        bitcnt <= bitcnt + 1'b1;
                    end else if (scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            sda_oe <= 1'b0;
                            state  <= ST_RACK;
                        end else begin
                            sda_oe <= ~tx_sr[7];
                            tx_sr  <= {tx_sr[6:0], 1'b0};
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mst_ack <= ~sda_q;
                    end else if (scl_fall) begin
                        if (mst_ack) begin
                            tx_sr  <= {rd_data[6:0], 1'b0};
                            sda_oe <= ~rd_data[7];
                            ptr    <= ptr + 1'b1;
                            state  <= ST_RDATA;
                        end else begin
                            state  <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/eep_target_chk.sv
// Protocol checker for the byte-memory target, attached through bind.
// Observes the FSM state, data-line drive, raw clock line and busy window.
module eep_target_chk
    import eep_pkg::*;
#(
    parameter int WR_CYCLES = 250000
) (
    input logic       clk,
    input logic       rst_n,
    input eep_state_t state,
    input logic       sda_oe,
    input logic       scl_i,
    input logic       busy,
    input logic       stop_det
);
    int unsigned busy_run;

    // Length of the current busy stretch, counted in clocks before this one.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_run <= 0;
        else                 busy_run <= busy_run + 1;
    end

    // R1: idle means no drive on the data line.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // R4: drive changes only while the bus clock is low.
    a_r4_drive_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    // R10: no identity acknowledge during the busy window.
    a_r10_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV_ACK) |-> !busy);

    // R10: the busy window never exceeds WR_CYCLES clocks.
    a_r10_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < WR_CYCLES));

    // R6: a busy window only ever follows a stop condition.
    a_r6_commit_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det));

endmodule

bind i2c_eeprom_target eep_target_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .sda_oe   (sda_oe),
    .scl_i    (scl_i),
    .busy     (busy),
    .stop_det (stop_det)
);

// File: tb/tb_i2c_eeprom_target.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_i2c_eeprom_target;

    localparam int Q      = 8;     // clocks per bus phase
    localparam int WR_CYC = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    logic [7:0] rb [0:7];

    always #10 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    i2c_eeprom_target #(.WR_CYCLES(WR_CYC)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (m_scl),
        .sda_i  (sda_line),
        .wp_i   (wp),
        .sda_oe (sda_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitq(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; waitq(Q);
        m_scl = 1'b1; waitq(Q);
        m_sda = 1'b0; waitq(Q);
        m_scl = 1'b0; waitq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; waitq(Q);
        m_scl = 1'b1; waitq(Q);
        m_sda = 1'b1; waitq(Q);
    endtask

    // Send a byte; ack=1 if the target pulled low in the ninth clock,
    // quiet=1 if it never drove during the eight data bits.
    task automatic send_byte(input logic [7:0] b, output logic ack, output logic quiet);
        quiet = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; waitq(Q);
            m_scl = 1'b1; waitq(Q/2);
            @(negedge clk); if (sda_oe) quiet = 1'b0;
            waitq(Q/2);
            m_scl = 1'b0; waitq(Q);
        end
        m_sda = 1'b1; waitq(Q);
        m_scl = 1'b1; waitq(Q/2);
        @(negedge clk); ack = ~sda_line;
        waitq(Q/2);
        m_scl = 1'b0; waitq(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; waitq(Q);
            m_scl = 1'b1; waitq(Q/2);
            @(negedge clk); b[i] = sda_line;
            waitq(Q/2);
            m_scl = 1'b0; waitq(Q);
        end
        m_sda = give_ack ? 1'b0 : 1'b1; waitq(Q);
        m_scl = 1'b1; waitq(Q);
        m_scl = 1'b0; waitq(Q);
    endtask

    task automatic poll(output logic ack);
        logic q;
        bus_start();
        send_byte(8'hA0, ack, q);
        bus_stop();
    endtask

    // Polls until acknowledged; returns the number of refused polls.
    task automatic wait_ready(output int nacks);
        logic a;
        nacks = 0;
        for (int k = 0; k < 20; k++) begin
            poll(a);
            if (a) break;
            nacks++;
        end
    endtask

    task automatic write_bytes(input logic [7:0] addr, input int n, input logic [7:0] base,
                               output logic all_ack, output logic all_quiet);
        logic a, q;
        all_ack = 1'b1; all_quiet = 1'b1;
        bus_start();
        send_byte(8'hA0, a, q); all_ack &= a; all_quiet &= q;
        send_byte(addr, a, q);  all_ack &= a; all_quiet &= q;
        for (int i = 0; i < n; i++) begin
            send_byte(base + 8'(i), a, q); all_ack &= a; all_quiet &= q;
        end
        bus_stop();
    endtask

    task automatic read_bytes(input logic [7:0] addr, input int n, output logic all_ack);
        logic a, q;
        all_ack = 1'b1;
        bus_start();
        send_byte(8'hA0, a, q); all_ack &= a;
        send_byte(addr, a, q);  all_ack &= a;
        bus_start();
        send_byte(8'hA1, a, q); all_ack &= a;
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rb[i]);
        bus_stop();
    endtask

    task automatic t_reset();
        logic a;
        check(sda_oe == 1'b0, "R11 drive off after reset", sda_oe, 0);
        read_bytes(8'h10, 1, a);
        check(rb[0] == 8'h00, "R11 array cleared", rb[0], 0);
    endtask

    task automatic t_no_start();
        logic a, q;
        send_byte(8'hA0, a, q);
        check(!a && q, "R1 no response before start", a, 0);
        bus_stop();
    endtask

    task automatic t_wrong_id();
        logic a, q;
        bus_start(); send_byte(8'hA2, a, q); bus_stop();
        check(!a, "R2 identity 1010001 refused", a, 0);
        bus_start(); send_byte(8'hB0, a, q); bus_stop();
        check(!a, "R2 identity 1011000 refused", a, 0);
    endtask

    task automatic t_byte_write();
        logic a, q;
        int   n;
        write_bytes(8'h10, 1, 8'hA5, a, q);
        check(a, "R2 R3 write identity, pointer and data acked", a, 1);
        check(q, "R4 no drive during master bits", q, 1);
        wait_ready(n);
        check(n >= 1 && n <= 4, "R10 busy polls refused then acked", n, 2);
        read_bytes(8'h10, 1, a);
        check(a, "R3 read identity acked", a, 1);
        check(rb[0] == 8'hA5, "R5 R6 random read after byte write", rb[0], 8'hA5);
    endtask

    task automatic t_page_wrap();
        logic a, q;
        int   n;
        write_bytes(8'h20, 16, 8'h40, a, q); wait_ready(n);
        write_bytes(8'h2E, 5, 8'h90, a, q);  wait_ready(n);
        read_bytes(8'h20, 4, a);
        check(rb[0] == 8'h92, "R7 wrap to offset 0", rb[0], 8'h92);
        check(rb[2] == 8'h94, "R7 wrap to offset 2", rb[2], 8'h94);
        check(rb[3] == 8'h43, "R6 page write kept offset 3", rb[3], 8'h43);
        read_bytes(8'h2E, 2, a);
        check(rb[0] == 8'h90 && rb[1] == 8'h91, "R7 offsets E and F", {rb[0], rb[1]}, 16'h9091);
    endtask

    task automatic t_seq_wrap();
        logic a, q;
        int   n;
        write_bytes(8'hFF, 1, 8'h5C, a, q); wait_ready(n);
        write_bytes(8'h00, 1, 8'hC3, a, q); wait_ready(n);
        read_bytes(8'hFE, 4, a);
        check(rb[0] == 8'h00 && rb[1] == 8'h5C, "R8 sequential read FE FF", {rb[0], rb[1]}, 16'h005C);
        check(rb[2] == 8'hC3 && rb[3] == 8'h00, "R8 wrap to 00 01", {rb[2], rb[3]}, 16'hC300);
        check(sda_oe == 1'b0, "R8 line released after no-ack", sda_oe, 0);
    endtask

    task automatic t_abort();
        logic a, q;
        bus_start();
        send_byte(8'hA0, a, q); send_byte(8'h50, a, q); send_byte(8'h66, a, q);
        bus_start();
        bus_stop();
        poll(a);
        check(a, "R6 no busy after aborted write", a, 1);
        read_bytes(8'h50, 1, a);
        check(rb[0] == 8'h00, "R6 aborted bytes not stored", rb[0], 0);
    endtask

    task automatic t_protect();
        logic a, q;
        wp = 1'b1;
        write_bytes(8'h60, 1, 8'h77, a, q);
        check(a, "R9 protected bytes still acked", a, 1);
        poll(a);
        check(a, "R9 no busy when protected", a, 1);
        read_bytes(8'h60, 1, a);
        check(rb[0] == 8'h00, "R9 protected write not stored", rb[0], 0);
        wp = 1'b0;
    endtask

    initial begin
        waitq(5);
        rst_n = 1'b1;
        waitq(5);
        @(negedge clk);
        t_reset();
        t_no_start();
        t_wrong_id();
        t_byte_write();
        t_page_wrap();
        t_seq_wrap();
        t_abort();
        t_protect();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule